// File: doc/BRIEF.md
# Dual Chroma-Key Video Fader

This block mixes two 4:2:2 YUV pixel streams, a primary video stream and an overlay stream, one sample per clock. Each sample carries a luma byte and a chroma byte. The chroma byte alternates between U and V, and a phase input says which one is present. For each overlay pixel, the block tests the Y value and the co-sited U/V pair against two programmable key windows. Each window has a low and a high bound for Y, for U and for V. When a window holds the pixel, the output is a weighted mix of the primary and overlay samples, using that window's fade factor. When no window holds it, the overlay sample passes through unchanged.

Each input port has its own number-format bit, so a port may carry offset-binary or two's-complement samples. Two's-complement samples are turned into offset binary before the keying compare and the mix, and the output is always offset binary. A colour-bar mode replaces the output picture with eight fixed bars, and the bars are indexed by a sample counter that restarts at horizontal sync. Settings are loaded through a write-only register port.

Internally, a pairing state machine tracks which chroma half of a pair sits in the first pipeline stage. Its states are ST_IDLE (no valid sample), ST_LEAD (a U sample), ST_TRAIL (a V sample that follows a U sample) and ST_STRAY (a V sample with no U before it). On every clock it moves as follows:

- An invalid input sends it to ST_IDLE.
- A valid U input sends it to ST_LEAD.
- A valid V input while in ST_LEAD sends it to ST_TRAIL.
- A valid V input in any other state sends it to ST_STRAY.

Top module: `ckf_fader`

## Requirements
- R1: After reset, out_valid, out_hsync and out_vsync are 0. Every key bound resets to 80h and both fade factors reset to 0. Colour bars are off and both ports are in offset-binary format.
- R2: A key window matches only when the overlay Y, U and V all lie within that window's bounds. The compare includes both bounds.
- R3: On a match with fade factor f (0 to 15), each output byte is (f*primary + (16-f)*overlay + 8) / 16, truncated and limited to 255.
- R4: When both windows match, window 1 (the lower register block) decides the fade factor.
- R5: When neither window matches, out_y and out_c equal the overlay Y and chroma after format conversion.
- R6: Control bit 1 selects the primary port's format and control bit 2 selects the overlay port's format: 1 means offset binary, 0 means two's complement. A two's-complement byte is converted by inverting bit 7.
- R7: in_cphase=0 marks a U sample and 1 marks a V sample. A U sample is keyed with its own U and the V of the next clock's sample, but only if that sample is valid with phase 1. A V sample is keyed with its own V and the U of the previous clock's sample, but only if that sample was valid with phase 0. A sample without such a partner never matches.
- R8: When control bit 0 is 1, out_y and out_c take bar values in place of the mix. The bar index is bits [3:1] of a sample counter. The counter reads 0 on any clock with in_hsync high and otherwise holds its stored value; it advances by one after each valid sample. The bars as (Y,U,V), indices 0 to 7, are: (180,128,128), (162,44,142), (131,156,44), (112,72,58), (84,184,198), (65,100,212), (35,212,114), (16,128,128). out_c gives U on phase 0 and V on phase 1.
- R9: out_valid, out_hsync, out_vsync, out_y and out_c show an input sample two clock edges after it is presented. The sync outputs follow the sync inputs on every clock, valid or not.
- R10: Window k (k=0,1) uses register addresses k*8+0 to k*8+5 for Y low, Y high, U low, U high, V low and V high. The fade factors sit at 10h and 11h in bits [3:0], and the control register is at 12h. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Input sample valid |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync |
| in_cphase | input | 1 | Chroma phase: 0 = U, 1 = V |
| vid_y | input | 8 | Primary stream luma |
| vid_c | input | 8 | Primary stream chroma |
| ovl_y | input | 8 | Overlay stream luma |
| ovl_c | input | 8 | Overlay stream chroma |
| out_valid | output | 1 | Output sample valid |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_y | output | 8 | Output luma |
| out_c | output | 8 | Output chroma |

## Verification
The hardest cases to reach are the broken chroma pairs. These include a U sample followed by an idle clock, a V sample arriving first after idle, and two U samples in a row. In these cases the key colours must not match, even though the pixel values would otherwise fall inside a window. The stimulus builds these from pixel values that are known to match, so a missing pairing check shows up as a blended output where pass-through is expected. Boundary pixels sit exactly on each bound and one step outside it. Because the two windows overlap, a miss in window 1 lands in window 2, and the resulting fade factor shows which window decided.

// File: rtl/ckf_pkg.sv
package ckf_pkg;

    localparam int PIX_W       = 8;
    localparam int LIM_PER_KEY = 6;

    localparam logic [4:0] ADDR_FADE_BASE = 5'h10;
    localparam logic [4:0] ADDR_CTRL      = 5'h12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_STRAY = 2'd3
    } pair_st_t;

    // Bar colours as {Y, U, V}, offset binary
    function automatic logic [23:0] bar_yuv(input logic [2:0] idx);
        logic [23:0] r;
        unique case (idx)
            3'd0: r = {8'd180, 8'd128, 8'd128};
            3'd1: r = {8'd162, 8'd44,  8'd142};
            3'd2: r = {8'd131, 8'd156, 8'd44};
            3'd3: r = {8'd112, 8'd72,  8'd58};
            3'd4: r = {8'd84,  8'd184, 8'd198};
            3'd5: r = {8'd65,  8'd100, 8'd212};
            3'd6: r = {8'd35,  8'd212, 8'd114};
            default: r = {8'd16, 8'd128, 8'd128};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ckf_regs.sv
module ckf_regs
    import ckf_pkg::*;
#(
    parameter int NK = 2,
    parameter int FW = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [4:0]                            addr,
    input  logic [PIX_W-1:0]                      wdata,
    output logic [NK-1:0][LIM_PER_KEY-1:0][PIX_W-1:0] lim,
    output logic [NK-1:0][FW-1:0]                 fade,
    output logic                                  bar_en,
    output logic                                  vid_fmt,
    output logic                                  ovl_fmt
);

    localparam logic [PIX_W-1:0] LIM_RST = PIX_W'(1) << (PIX_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim     <= {(NK * LIM_PER_KEY){LIM_RST}};
            fade    <= '0;
            bar_en  <= 1'b0;
            vid_fmt <= 1'b1;
            ovl_fmt <= 1'b1;
        end else if (we) begin
            for (int k = 0; k < NK; k++) begin
                if (addr[4] == 1'b0 && addr[3] == k[0] && addr[2:0] < 3'(LIM_PER_KEY))
                    lim[k][addr[2:0]] <= wdata;
                if (addr == ADDR_FADE_BASE + 5'(k))
                    fade[k] <= wdata[FW-1:0];
            end
            if (addr == ADDR_CTRL) begin
                bar_en  <= wdata[0];
                vid_fmt <= wdata[1];
                ovl_fmt <= wdata[2];
            end
        end
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_CTRL) |=> (bar_en == $past(wdata[0]) && ovl_fmt == $past(wdata[2]))); // R10

endmodule

// File: rtl/ckf_window.sv
module ckf_window
    import ckf_pkg::*;
(
    input  logic [PIX_W-1:0]                    y,
    input  logic [PIX_W-1:0]                    u,
    input  logic [PIX_W-1:0]                    v,
    input  logic [LIM_PER_KEY-1:0][PIX_W-1:0]   lim,
    output logic                                hit
);

    logic y_in, u_in, v_in;

    always_comb begin
        y_in = (y >= lim[0]) && (y <= lim[1]);
        u_in = (u >= lim[2]) && (u <= lim[3]);
        v_in = (v >= lim[4]) && (v <= lim[5]);
        hit  = y_in && u_in && v_in;
    end

endmodule

// File: rtl/ckf_blend.sv
module ckf_blend
    import ckf_pkg::*;
#(
    parameter int FW = 4
) (
    input  logic [PIX_W-1:0] pri,
    input  logic [PIX_W-1:0] ovl,
    input  logic [FW-1:0]    fade,
    output logic [PIX_W-1:0] mix
);

    localparam int SW = PIX_W + FW + 2;
    localparam logic [SW-1:0] ONE  = SW'(1) << FW;
    localparam logic [SW-1:0] HALF = SW'(1) << (FW - 1);
    localparam logic [SW-1:0] PMAX = SW'((1 << PIX_W) - 1);

    logic [SW-1:0] w_pri, w_ovl, sum, quo;

    always_comb begin
        w_pri = SW'(fade);
        w_ovl = ONE - w_pri;
        sum   = w_pri * SW'(pri) + w_ovl * SW'(ovl) + HALF;
        quo   = sum >> FW;
        mix   = (quo > PMAX) ? PMAX[PIX_W-1:0] : quo[PIX_W-1:0];
    end

endmodule

// File: rtl/ckf_bars.sv
module ckf_bars
    import ckf_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int BAR_SHIFT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_hsync,
    input  logic             in_cphase,
    output logic [PIX_W-1:0] bar_y,
    output logic [PIX_W-1:0] bar_c
);

    localparam int IDX_HI = BAR_SHIFT + 2;

    logic [CNT_W-1:0] cnt_q, idx;
    logic [23:0]      yuv;

    assign idx = in_hsync ? '0 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (in_valid) cnt_q <= idx + CNT_W'(1);
        else               cnt_q <= idx;
    end

    always_comb begin
        yuv   = bar_yuv(idx[IDX_HI:BAR_SHIFT]);
        bar_y = yuv[23:16];
        bar_c = in_cphase ? yuv[7:0] : yuv[15:8];
    end

    AST_BAR_HSYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hsync && in_valid) |=> (cnt_q == CNT_W'(1))); // R8

endmodule

// File: rtl/ckf_fader.sv
module ckf_fader
    import ckf_pkg::*;
#(
    parameter int FADE_W    = 4,
    parameter int CNT_W     = 12,
    parameter int BAR_SHIFT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [4:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             in_valid,
    input  logic             in_hsync,
    input  logic             in_vsync,
    input  logic             in_cphase,
    input  logic [7:0]       vid_y,
    input  logic [7:0]       vid_c,
    input  logic [7:0]       ovl_y,
    input  logic [7:0]       ovl_c,
    output logic             out_valid,
    output logic             out_hsync,
    output logic             out_vsync,
    output logic [7:0]       out_y,
    output logic [7:0]       out_c
);

    localparam int NK = 2;
    localparam logic [PIX_W-1:0] MSB = PIX_W'(1) << (PIX_W - 1);

    logic [NK-1:0][LIM_PER_KEY-1:0][PIX_W-1:0] lim;
    logic [NK-1:0][FADE_W-1:0]                 fade;
    logic bar_en, vid_fmt, ovl_fmt;

    ckf_regs #(.NK(NK), .FW(FADE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .lim(lim), .fade(fade), .bar_en(bar_en), .vid_fmt(vid_fmt), .ovl_fmt(ovl_fmt)
    );

    // Format conversion at the input
    logic [PIX_W-1:0] cv_vy, cv_vc, cv_oy, cv_oc;
    always_comb begin
        cv_vy = vid_fmt ? vid_y : (vid_y ^ MSB);
        cv_vc = vid_fmt ? vid_c : (vid_c ^ MSB);
        cv_oy = ovl_fmt ? ovl_y : (ovl_y ^ MSB);
        cv_oc = ovl_fmt ? ovl_c : (ovl_c ^ MSB);
    end

    logic [PIX_W-1:0] in_bar_y, in_bar_c;
    ckf_bars #(.CNT_W(CNT_W), .BAR_SHIFT(BAR_SHIFT)) u_bars (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hsync(in_hsync),
        .in_cphase(in_cphase), .bar_y(in_bar_y), .bar_c(in_bar_c)
    );

    // Stage 1 registers and pairing state
    pair_st_t         state, nxt;
    logic             s1_valid, s1_hs, s1_vs;
    logic [PIX_W-1:0] s1_vy, s1_vc, s1_oy, s1_oc, s1_bar_y, s1_bar_c, held_u;

    always_comb begin
        if (!in_valid)                    nxt = ST_IDLE;
        else if (!in_cphase)              nxt = ST_LEAD;
        else if (state == ST_LEAD)        nxt = ST_TRAIL;
        else                              nxt = ST_STRAY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0; s1_hs <= 1'b0; s1_vs <= 1'b0;
            s1_vy <= '0; s1_vc <= '0; s1_oy <= '0; s1_oc <= '0;
            s1_bar_y <= '0; s1_bar_c <= '0; held_u <= '0;
        end else begin
            s1_valid <= in_valid; s1_hs <= in_hsync; s1_vs <= in_vsync;
            s1_vy <= cv_vy; s1_vc <= cv_vc; s1_oy <= cv_oy; s1_oc <= cv_oc;
            s1_bar_y <= in_bar_y; s1_bar_c <= in_bar_c;
            if (state == ST_LEAD) held_u <= s1_oc;
        end
    end

    // Key operand selection driven by pairing state
    logic [PIX_W-1:0] key_u, key_v;
    logic             pair_ok;
    always_comb begin
        key_u   = s1_oc;
        key_v   = s1_oc;
        pair_ok = 1'b0;
        unique case (state)
            ST_IDLE:  pair_ok = 1'b0;
            ST_LEAD: begin
                key_u   = s1_oc;
                key_v   = cv_oc;
                pair_ok = in_valid && in_cphase;
            end
            ST_TRAIL: begin
                key_u   = held_u;
                key_v   = s1_oc;
                pair_ok = 1'b1;
            end
            ST_STRAY: pair_ok = 1'b0;
        endcase
    end

    logic [NK-1:0] win_hit, hit;
    for (genvar k = 0; k < NK; k++) begin : g_key
        ckf_window u_win (
            .y(s1_oy), .u(key_u), .v(key_v), .lim(lim[k]), .hit(win_hit[k])
        );
        assign hit[k] = pair_ok && win_hit[k];
    end

    logic [FADE_W-1:0] fade_sel;
    always_comb begin
        if (hit[0])      fade_sel = fade[0];
        else if (hit[1]) fade_sel = fade[1];
        else             fade_sel = '0;
    end

    logic [PIX_W-1:0] mix_y, mix_c;
    ckf_blend #(.FW(FADE_W)) u_blend_y (.pri(s1_vy), .ovl(s1_oy), .fade(fade_sel), .mix(mix_y));
    ckf_blend #(.FW(FADE_W)) u_blend_c (.pri(s1_vc), .ovl(s1_oc), .fade(fade_sel), .mix(mix_c));

    // Stage 2 output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_hsync <= 1'b0; out_vsync <= 1'b0;
            out_y <= '0; out_c <= '0;
        end else begin
            out_valid <= s1_valid; out_hsync <= s1_hs; out_vsync <= s1_vs;
            out_y <= bar_en ? s1_bar_y : mix_y;
            out_c <= bar_en ? s1_bar_c : mix_c;
        end
    end

    // Edges seen since reset, saturating, for history-based checks
    logic [1:0] live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              live_q <= '0;
        else if (live_q != 2'd3) live_q <= live_q + 2'd1;
    end

    logic [PIX_W-1:0] lo_y, hi_y;
    assign lo_y = (s1_vy < s1_oy) ? s1_vy : s1_oy;
    assign hi_y = (s1_vy < s1_oy) ? s1_oy : s1_vy;

    AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q >= 2'd2) |-> (out_valid == $past(in_valid, 2) && out_hsync == $past(in_hsync, 2)
                              && out_vsync == $past(in_vsync, 2))); // R9
    AST_TRAIL_FOLLOWS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q >= 2'd1 && state == ST_TRAIL) |-> ($past(state) == ST_LEAD)); // R7
    AST_KEY1_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && hit[1]) |-> (fade_sel == fade[0])); // R4
    AST_NOKEY_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q >= 2'd1 && $past(s1_valid && hit == '0 && !bar_en))
        |-> (out_y == $past(s1_oy) && out_c == $past(s1_oc))); // R5
    AST_BLEND_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q >= 2'd1 && $past(s1_valid && !bar_en))
        |-> (out_y >= $past(lo_y) && out_y <= $past(hi_y))); // R3

endmodule

// File: tb/tb_ckf_fader.sv
module tb_ckf_fader;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       in_valid = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0, in_cphase = 1'b0;
    logic [7:0] vid_y = '0, vid_c = '0, ovl_y = '0, ovl_c = '0;
    logic       out_valid, out_hsync, out_vsync;
    logic [7:0] out_y, out_c;

    ckf_fader dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync), .in_cphase(in_cphase),
        .vid_y(vid_y), .vid_c(vid_c), .ovl_y(ovl_y), .ovl_c(ovl_c),
        .out_valid(out_valid), .out_hsync(out_hsync), .out_vsync(out_vsync),
        .out_y(out_y), .out_c(out_c)
    );

    typedef struct {
        bit       v, hs, vs;
        bit [7:0] y, c;
        int       due;
        string    req;
    } exp_t;

    exp_t  q[$];
    int    cyc = 0;
    int    checks = 0, errors = 0;
    bit    done = 0;
    string cur_req = "R9";

    always @(posedge clk) cyc <= cyc + 1;

    // Model of programmed state
    bit [7:0] m_lim[2][6];
    int       m_fade[2];
    bit       m_bar, m_vf, m_of;
    int       m_cnt;

    // Burst buffer
    bit       b_v[32], b_ph[32], b_hs[32], b_vs[32];
    bit [7:0] b_vy[32], b_vc[32], b_oy[32], b_oc[32];
    int       bn = 0;

    function automatic bit [7:0] cv(bit [7:0] x, bit fmt);
        return fmt ? x : (x ^ 8'h80);
    endfunction

    function automatic bit [7:0] mixv(int f, int a, int b);
        int s;
        s = (f * a + (16 - f) * b + 8) / 16;
        if (s > 255) s = 255;
        return 8'(s);
    endfunction

    function automatic bit inwin(int k, bit [7:0] y, bit [7:0] u, bit [7:0] v);
        return y >= m_lim[k][0] && y <= m_lim[k][1] && u >= m_lim[k][2] && u <= m_lim[k][3]
            && v >= m_lim[k][4] && v <= m_lim[k][5];
    endfunction

    function automatic bit [23:0] bar_tab(int i);
        case (i)
            0: return {8'd180, 8'd128, 8'd128};
            1: return {8'd162, 8'd44,  8'd142};
            2: return {8'd131, 8'd156, 8'd44};
            3: return {8'd112, 8'd72,  8'd58};
            4: return {8'd84,  8'd184, 8'd198};
            5: return {8'd65,  8'd100, 8'd212};
            6: return {8'd35,  8'd212, 8'd114};
            default: return {8'd16, 8'd128, 8'd128};
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(bit [4:0] a, bit [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a[4] == 1'b0 && a[2:0] < 3'd6) m_lim[a[3]][a[2:0]] = d;
        if (a == 5'h10) m_fade[0] = d & 15;
        if (a == 5'h11) m_fade[1] = d & 15;
        if (a == 5'h12) begin m_bar = d[0]; m_vf = d[1]; m_of = d[2]; end
    endtask

    task automatic add(bit v, bit ph, bit hs, bit vs, bit [7:0] vy, bit [7:0] vc,
                       bit [7:0] oy, bit [7:0] oc);
        b_v[bn] = v; b_ph[bn] = ph; b_hs[bn] = hs; b_vs[bn] = vs;
        b_vy[bn] = vy; b_vc[bn] = vc; b_oy[bn] = oy; b_oc[bn] = oc;
        bn++;
    endtask

    // Driver: compute expectation per sample, push, then drive
    task automatic run_burst();
        for (int i = 0; i < bn; i++) begin
            exp_t     e;
            bit       paired;
            bit [7:0] ku, kv, oy, oc;
            int       f, idx;
            paired = 0; ku = 0; kv = 0;
            oy = cv(b_oy[i], m_of);
            oc = cv(b_oc[i], m_of);
            if (b_v[i] && !b_ph[i] && i + 1 < bn && b_v[i+1] && b_ph[i+1]) begin
                paired = 1; ku = oc; kv = cv(b_oc[i+1], m_of);
            end else if (b_v[i] && b_ph[i] && i > 0 && b_v[i-1] && !b_ph[i-1]) begin
                paired = 1; ku = cv(b_oc[i-1], m_of); kv = oc;
            end
            f = 0;
            if (paired && inwin(0, oy, ku, kv))      f = m_fade[0];
            else if (paired && inwin(1, oy, ku, kv)) f = m_fade[1];
            idx = b_hs[i] ? 0 : m_cnt;
            m_cnt = b_v[i] ? (idx + 1) % 4096 : idx;
            e.v = b_v[i]; e.hs = b_hs[i]; e.vs = b_vs[i]; e.req = cur_req;
            if (m_bar) begin
                bit [23:0] t;
                t = bar_tab((idx >> 1) & 7);
                e.y = t[23:16];
                e.c = b_ph[i] ? t[7:0] : t[15:8];
            end else begin
                e.y = mixv(f, cv(b_vy[i], m_vf), oy);
                e.c = mixv(f, cv(b_vc[i], m_vf), oc);
            end
            @(negedge clk);
            in_valid = b_v[i]; in_cphase = b_ph[i]; in_hsync = b_hs[i]; in_vsync = b_vs[i];
            vid_y = b_vy[i]; vid_c = b_vc[i]; ovl_y = b_oy[i]; ovl_c = b_oc[i];
            e.due = cyc + 2;
            q.push_back(e);
        end
        @(negedge clk);
        in_valid = 0; in_hsync = 0; in_vsync = 0; in_cphase = 0;
        bn = 0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(out_valid == e.v, "R9", "out_valid", out_valid, e.v);
                chk(out_hsync == e.hs, "R9", "out_hsync", out_hsync, e.hs);
                chk(out_vsync == e.vs, "R9", "out_vsync", out_vsync, e.vs);
                if (e.v) begin
                    chk(out_y == e.y, e.req, "out_y", out_y, e.y);
                    chk(out_c == e.c, e.req, "out_c", out_c, e.c);
                end
            end else if (rst_n && out_valid) begin
                chk(0, "R9", "unexpected out_valid", 1, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            for (int j = 0; j < 6; j++) m_lim[k][j] = 8'h80;
            m_fade[k] = 0;
        end
        m_bar = 0; m_vf = 1; m_of = 1; m_cnt = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs
        chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        chk(out_hsync == 0, "R1", "out_hsync after reset", out_hsync, 0);
        chk(out_vsync == 0, "R1", "out_vsync after reset", out_vsync, 0);

        // R1: default fade 0 passes overlay even on an 80h match
        cur_req = "R1";
        add(1, 0, 0, 0, 8'h40, 8'h20, 8'h80, 8'h80);
        add(1, 1, 0, 0, 8'h40, 8'h60, 8'h80, 8'h80);
        run_burst();
        // R1: default bounds 80h; 80h pixel blends, 81h does not
        wr(5'h10, 8'h08);
        add(1, 0, 1, 0, 8'h40, 8'h20, 8'h80, 8'h80);
        add(1, 1, 0, 0, 8'h40, 8'h60, 8'h80, 8'h80);
        add(1, 0, 0, 1, 8'h40, 8'h20, 8'h81, 8'h80);
        add(1, 1, 0, 0, 8'h40, 8'h60, 8'h81, 8'h80);
        run_burst();

        // R10: program both windows through the register map
        wr(5'h00, 8'h40); wr(5'h01, 8'hA0); wr(5'h02, 8'h60); wr(5'h03, 8'h70);
        wr(5'h04, 8'h90); wr(5'h05, 8'hA0);
        wr(5'h08, 8'h10); wr(5'h09, 8'hF0); wr(5'h0A, 8'h50); wr(5'h0B, 8'h80);
        wr(5'h0C, 8'h80); wr(5'h0D, 8'hB0);
        wr(5'h10, 8'hFC); wr(5'h11, 8'h04);

        // R2 / R4: bounds inclusive, overlapping windows, key 1 wins
        cur_req = "R2";
        add(1, 0, 0, 0, 8'h10, 8'hE0, 8'h40, 8'h60);  // Y,U at key1 low bounds
        add(1, 1, 0, 0, 8'h20, 8'hD0, 8'hA0, 8'hA0);  // Y,V at key1 high bounds
        add(1, 0, 0, 0, 8'h10, 8'hE0, 8'hA1, 8'h65);  // Y over key1 -> key2
        add(1, 1, 0, 0, 8'h20, 8'hD0, 8'h3F, 8'h95);  // Y under key1 -> key2
        add(1, 0, 0, 0, 8'hF0, 8'h00, 8'hF1, 8'h65);  // no window
        add(1, 1, 0, 0, 8'hF0, 8'h00, 8'hF1, 8'h95);
        add(1, 0, 0, 0, 8'h30, 8'h30, 8'h50, 8'h71);  // U over key1 -> key2
        add(1, 1, 0, 0, 8'h30, 8'h30, 8'h50, 8'h95);
        run_burst();
        cur_req = "R4";
        add(1, 0, 0, 0, 8'hC8, 8'h10, 8'h50, 8'h65);  // both windows
        add(1, 1, 0, 0, 8'hC8, 8'hF0, 8'h50, 8'h95);
        add(1, 0, 0, 0, 8'hC8, 8'h10, 8'h50, 8'h75);  // key2 only
        add(1, 1, 0, 0, 8'hC8, 8'hF0, 8'h50, 8'h85);
        run_burst();

        // R3: extreme mix, fade 15, rounding
        cur_req = "R3";
        wr(5'h10, 8'h0F);
        add(1, 0, 0, 0, 8'hFF, 8'h00, 8'h50, 8'h65);
        add(1, 1, 0, 0, 8'h00, 8'hFF, 8'h50, 8'h95);
        add(1, 0, 0, 0, 8'h01, 8'h02, 8'h50, 8'h65);
        add(1, 1, 0, 0, 8'h03, 8'hFE, 8'h50, 8'h95);
        run_burst();

        // R5: non-matching overlay passes through
        cur_req = "R5";
        add(1, 0, 0, 0, 8'h12, 8'h34, 8'hFE, 8'h01);
        add(1, 1, 0, 0, 8'h56, 8'h78, 8'h02, 8'hFD);
        run_burst();

        // R7: broken pairs never key, even with matching values
        cur_req = "R7";
        add(1, 0, 0, 0, 8'hFF, 8'hFF, 8'h50, 8'h65);  // U then idle
        add(0, 1, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00);
        add(1, 1, 0, 0, 8'hFF, 8'hFF, 8'h50, 8'h95);  // stray V
        add(1, 0, 0, 0, 8'hFF, 8'hFF, 8'h50, 8'h65);  // U then U
        add(1, 0, 0, 0, 8'hFF, 8'hFF, 8'h50, 8'h65);  // paired lead
        add(1, 1, 0, 0, 8'hFF, 8'hFF, 8'h50, 8'h95);  // paired trail
        add(1, 1, 0, 0, 8'hFF, 8'hFF, 8'h50, 8'h95);  // V after V
        run_burst();
        // R7: key uses the partner's chroma, not the own sample twice
        add(1, 0, 0, 0, 8'hFF, 8'hFF, 8'h50, 8'h65);
        add(1, 1, 0, 0, 8'hFF, 8'hFF, 8'h50, 8'h10);  // V outside both
        run_burst();

        // R6: two's-complement on both ports
        cur_req = "R6";
        wr(5'h12, 8'h00);
        add(1, 0, 0, 0, 8'h7F, 8'h80, 8'hD0, 8'hE5);
        add(1, 1, 0, 0, 8'h00, 8'h10, 8'hD0, 8'h15);
        run_burst();
        wr(5'h12, 8'h02);  // primary offset binary, overlay two's complement
        add(1, 0, 0, 0, 8'h7F, 8'h80, 8'hD0, 8'hE5);
        add(1, 1, 0, 0, 8'h00, 8'h10, 8'hD0, 8'h15);
        add(1, 0, 0, 0, 8'h7F, 8'h80, 8'h50, 8'h65);  // no match once converted
        add(1, 1, 0, 0, 8'h00, 8'h10, 8'h50, 8'h95);
        run_burst();

        // R8: colour bars with line restarts
        cur_req = "R8";
        wr(5'h12, 8'h07);
        add(0, 0, 1, 1, 8'h00, 8'h00, 8'h00, 8'h00);
        for (int i = 0; i < 18; i++)
            add(1, i[0], 0, 0, 8'(i), 8'(i), 8'(i), 8'(i));
        add(0, 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00);
        add(1, 0, 1, 0, 8'h00, 8'h00, 8'h50, 8'h65);
        for (int i = 1; i < 6; i++)
            add(1, i[0], 0, 0, 8'h00, 8'h00, 8'h50, 8'h65);
        run_burst();

        // R10: unmapped addresses leave settings unchanged
        cur_req = "R10";
        wr(5'h12, 8'h06);
        wr(5'h06, 8'h00); wr(5'h07, 8'hFF); wr(5'h0E, 8'h00);
        wr(5'h13, 8'hFF); wr(5'h1F, 8'hFF);
        add(1, 0, 0, 0, 8'hFF, 8'h00, 8'h50, 8'h65);
        add(1, 1, 0, 0, 8'h00, 8'hFF, 8'h50, 8'h95);
        add(1, 0, 0, 0, 8'h10, 8'hE0, 8'hA1, 8'h65);
        add(1, 1, 0, 0, 8'h20, 8'hD0, 8'h3F, 8'h95);
        run_burst();
        // R10: narrowing key2 V high via its own address removes the key2 hit
        wr(5'h0D, 8'h90);
        add(1, 0, 0, 0, 8'hC8, 8'h10, 8'h50, 8'h75);
        add(1, 1, 0, 0, 8'hC8, 8'hF0, 8'h50, 8'h95);
        run_burst();

        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R9", "pending expectations", q.size(), 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule